// File: doc/BRIEF.md
# Frame-Clock Channel Pair Aligner

This block sits behind a group of interleaved-channel converters on the receive side. Each converter delivers one sample word per input-clock cycle, together with the level of its own frame clock and a valid flag. A low frame-clock level marks an odd-channel sample. A high level marks an even-channel sample. One frame therefore spans two input clocks. Each converter's frame phase is arbitrary and cannot be forced, so every stream is classified on its own and joined into an (odd, even) pair.

When every device has completed a frame, the block copies all pairs into one wide output word and raises a single-cycle valid strobe. Odd channels from all devices then appear together, each with the even channel that followed it on the same device. The devices may sit up to one input clock apart. After reset, a device's samples are ignored until its frame clock has been seen to change level. An even half that has no odd half before it is never used. If a device finishes a second frame before the strobe has taken its first one, a sticky error flag is raised for that device.

Top module: `pair_aligner`

## Requirements
- R1: While `rst` is high at a rising clock edge, `frame_valid`, `frame_out` and `overrun` all become zero.
- R2: For each device d, `frame_out` bits `[d*2*SAMPLE_W +: SAMPLE_W]` hold the odd sample, taken while that device's frame level was 0. The bits just above them hold the even sample, taken while the level was 1.
- R3: An even sample is joined only to the most recent odd sample of the same device. The pair is completed on the cycle the even sample is taken.
- R4: After reset, a device's samples are discarded up to its first valid sample whose frame level differs from that of its previous valid sample. That sample itself is usable. An even sample with no stored odd half is dropped.
- R5: `frame_valid` is high for exactly one cycle at a time. It rises only after every device holds a completed pair, and the strobe then clears all completed-pair flags.
- R6: If the last device's pair completes at clock edge k, then `frame_valid` is high and `frame_out` is updated after edge k+1.
- R7: `overrun[d]` is set when device d completes a pair while its earlier pair is still waiting and no strobe occurs at that edge. The bit stays set until reset.
- R8: A cycle with `dev_valid[d]` low has no effect on device d. It does not change the stored odd half, the frame-level history, or the completed pair.
- R9: `frame_out` keeps its value in every cycle in which `frame_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input-clock domain clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_data | input | N_DEV*SAMPLE_W | Sample word per device, device d at bits [d*SAMPLE_W +: SAMPLE_W] |
| dev_fclk | input | N_DEV | Frame-clock level per device (0 odd, 1 even) |
| dev_valid | input | N_DEV | Sample-valid flag per device |
| frame_out | output | N_DEV*2*SAMPLE_W | Aligned frame, device-major, odd half low, even half high |
| frame_valid | output | 1 | One-cycle strobe marking a new aligned frame |
| overrun | output | N_DEV | Sticky per-device overrun error |

## Verification
The bench targets the following corner cases:
- **Start-up with an even half.** A stream that starts with even samples must be dropped. A design that pairs too early would join an even sample to a stale or zero odd half, and the first frame's lower words would be wrong.
- **One-cycle phase offset.** Devices run with offsets of zero or one cycle. A design that strobes on one device's completion, or that fails to clear its flags, would emit frames that mix two frames or repeat the same frame.
- **Invalid-cycle gaps.** Gaps are inserted inside a frame. A design that treats a gap as a level change or as a sample would split pairs or arm early.
- **Overrun.** A silent device is used to force a double completion. This shows whether the error flag is set, stays set, and stays limited to the offending devices.

// File: rtl/pair_align_pkg.sv
package pair_align_pkg;

  // Which half of a frame a sample belongs to, decoded from the frame-clock level.
  typedef enum logic {
    HALF_ODD  = 1'b0,
    HALF_EVEN = 1'b1
  } half_e;

  function automatic half_e decode_half(input logic level);
    return level ? HALF_EVEN : HALF_ODD;
  endfunction

endpackage

// File: rtl/pa_lane.sv
module pa_lane
  import pair_align_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  localparam int PAIR_W = 2 * SAMPLE_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SAMPLE_W-1:0] s_data,
  input  logic                s_fclk,
  input  logic                s_valid,
  input  logic                clr,
  output logic [PAIR_W-1:0]   pair_q,
  output logic                ready_q,
  output logic                overrun_q
);

  logic                have_prev;
  logic                prev_lvl;
  logic                armed;
  logic                hold_full;
  logic [SAMPLE_W-1:0] hold_q;

  half_e half;
  logic  level_edge;
  logic  usable;
  logic  complete;

  assign half       = decode_half(s_fclk);
  assign level_edge = s_valid && have_prev && (s_fclk != prev_lvl);
  assign usable     = s_valid && (armed || level_edge);
  assign complete   = usable && (half == HALF_EVEN) && hold_full;

  // frame-level history and arming
  always_ff @(posedge clk) begin
    if (rst) begin
      have_prev <= 1'b0;
      prev_lvl  <= 1'b0;
      armed     <= 1'b0;
    end else begin
      if (s_valid) begin
        have_prev <= 1'b1;
        prev_lvl  <= s_fclk;
      end
      if (level_edge) armed <= 1'b1;
    end
  end

  // first-half holding register
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_full <= 1'b0;
      hold_q    <= '0;
    end else if (usable && half == HALF_ODD) begin
      hold_full <= 1'b1;
      hold_q    <= s_data;
    end else if (complete) begin
      hold_full <= 1'b0;
    end
  end

  // completed pair, ready flag and sticky overrun
  always_ff @(posedge clk) begin
    if (rst) begin
      pair_q    <= '0;
      ready_q   <= 1'b0;
      overrun_q <= 1'b0;
    end else begin
      if (complete) pair_q <= {s_data, hold_q};
      ready_q <= (ready_q && !clr) || complete;
      if (complete && ready_q && !clr) overrun_q <= 1'b1;
    end
  end

endmodule

// File: rtl/pa_gather.sv
module pa_gather #(
  parameter int N_DEV    = 4,
  parameter int SAMPLE_W = 12,
  localparam int OUT_W = N_DEV * 2 * SAMPLE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_DEV-1:0] ready,
  input  logic [OUT_W-1:0] pairs,
  output logic             clr,
  output logic [OUT_W-1:0] out_q,
  output logic             valid_q
);

  assign clr = &ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      out_q   <= '0;
    end else begin
      valid_q <= clr;
      if (clr) out_q <= pairs;
    end
  end

endmodule

// File: rtl/pair_aligner.sv
module pair_aligner #(
  parameter int N_DEV    = 4,
  parameter int SAMPLE_W = 12,
  localparam int PAIR_W = 2 * SAMPLE_W,
  localparam int IN_W   = N_DEV * SAMPLE_W,
  localparam int OUT_W  = N_DEV * PAIR_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IN_W-1:0]  dev_data,
  input  logic [N_DEV-1:0] dev_fclk,
  input  logic [N_DEV-1:0] dev_valid,
  output logic [OUT_W-1:0] frame_out,
  output logic             frame_valid,
  output logic [N_DEV-1:0] overrun
);

  logic [N_DEV-1:0] lane_ready;
  logic [OUT_W-1:0] lane_pairs;
  logic             strobe_clr;

  for (genvar d = 0; d < N_DEV; d++) begin : g_lane
    pa_lane #(.SAMPLE_W(SAMPLE_W)) u_lane (
      .clk      (clk),
      .rst      (rst),
      .s_data   (dev_data[d*SAMPLE_W +: SAMPLE_W]),
      .s_fclk   (dev_fclk[d]),
      .s_valid  (dev_valid[d]),
      .clr      (strobe_clr),
      .pair_q   (lane_pairs[d*PAIR_W +: PAIR_W]),
      .ready_q  (lane_ready[d]),
      .overrun_q(overrun[d])
    );
  end

  pa_gather #(.N_DEV(N_DEV), .SAMPLE_W(SAMPLE_W)) u_gather (
    .clk    (clk),
    .rst    (rst),
    .ready  (lane_ready),
    .pairs  (lane_pairs),
    .clr    (strobe_clr),
    .out_q  (frame_out),
    .valid_q(frame_valid)
  );

endmodule

// File: rtl/pair_aligner_chk.sv
module pair_aligner_chk #(
  parameter int N_DEV    = 4,
  parameter int SAMPLE_W = 12,
  localparam int OUT_W = N_DEV * 2 * SAMPLE_W
) (
  input logic             clk,
  input logic             rst,
  input logic [OUT_W-1:0] frame_out,
  input logic             frame_valid,
  input logic [N_DEV-1:0] overrun,
  input logic [N_DEV-1:0] lane_ready
);

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!frame_valid && overrun == '0 && frame_out == '0));

  p_single_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    frame_valid |=> !frame_valid);

  p_strobe_needs_all_r5: assert property (@(posedge clk) disable iff (rst)
    frame_valid |-> $past(&lane_ready));

  p_strobe_latency_r6: assert property (@(posedge clk) disable iff (rst)
    (&lane_ready) |=> frame_valid);

  p_overrun_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (|overrun) |=> ((overrun & $past(overrun)) == $past(overrun)));

  p_hold_output_r9: assert property (@(posedge clk) disable iff (rst)
    !frame_valid |-> $stable(frame_out));

endmodule

bind pair_aligner pair_aligner_chk #(.N_DEV(N_DEV), .SAMPLE_W(SAMPLE_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .frame_out  (frame_out),
  .frame_valid(frame_valid),
  .overrun    (overrun),
  .lane_ready (lane_ready)
);

// File: tb/pair_aligner_bench.sv
module pair_aligner_bench;
  localparam int ND = 4;
  localparam int W  = 12;
  localparam int PW = 2 * W;
  localparam int NROWS = 24;
  // each row: {valid[3:0], fclk[3:0]}
  localparam logic [7:0] TBL [NROWS] = '{
    8'hF3, 8'hFC, 8'hF3, 8'hFC, 8'hF3, 8'hFC, 8'hF3, 8'hFC,
    8'hDC, 8'hD3, 8'hFC, 8'hF3, 8'hFC, 8'hF3, 8'h0C, 8'h03,
    8'hFC, 8'hF3, 8'hFC, 8'hF3, 8'hFC, 8'hF3, 8'hFC, 8'hF3
  };

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1;
  logic [ND*W-1:0]  dev_data = '0;
  logic [ND-1:0]    dev_fclk = '0;
  logic [ND-1:0]    dev_valid = '0;
  logic [ND*PW-1:0] frame_out;
  logic             frame_valid;
  logic [ND-1:0]    overrun;

  pair_aligner #(.N_DEV(ND), .SAMPLE_W(W)) u_pair_aligner (
    .clk(clk), .rst(rst), .dev_data(dev_data), .dev_fclk(dev_fclk),
    .dev_valid(dev_valid), .frame_out(frame_out), .frame_valid(frame_valid),
    .overrun(overrun)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  // reference model state, built from the requirements
  bit m_hp[ND], m_pl[ND], m_arm[ND], m_hf[ND], m_rdy[ND];
  logic [ND-1:0]    m_ovr;
  logic [W-1:0]     m_hold[ND];
  logic [PW-1:0]    m_pair[ND];
  logic [ND*PW-1:0] m_out;
  bit               m_val;

  function automatic logic [W-1:0] dat(input int d, input int c);
    return W'(d * 37 + c * 5 + 1);
  endfunction

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic model_reset();
    for (int d = 0; d < ND; d++) begin
      m_hp[d] = 0; m_pl[d] = 0; m_arm[d] = 0; m_hf[d] = 0; m_rdy[d] = 0;
      m_hold[d] = '0; m_pair[d] = '0;
    end
    m_ovr = '0; m_out = '0; m_val = 0;
  endtask

  task automatic model_step();
    bit all;
    all = 1;
    for (int d = 0; d < ND; d++) all &= m_rdy[d];
    m_val = all;
    if (all) for (int d = 0; d < ND; d++) m_out[d*PW +: PW] = m_pair[d];
    for (int d = 0; d < ND; d++) begin
      bit v, f, chg, use_it, comp;
      v = dev_valid[d]; f = dev_fclk[d];
      chg = v && m_hp[d] && (f != m_pl[d]);
      use_it = v && (m_arm[d] || chg);
      comp = use_it && f && m_hf[d];
      if (chg) m_arm[d] = 1;
      if (v) begin m_hp[d] = 1; m_pl[d] = f; end
      if (comp) begin
        if (m_rdy[d] && !all) m_ovr[d] = 1'b1;
        m_pair[d] = {dev_data[d*W +: W], m_hold[d]};
        m_hf[d] = 0;
        m_rdy[d] = 1;
      end else begin
        m_rdy[d] = m_rdy[d] && !all;
      end
      if (use_it && !f) begin m_hold[d] = dev_data[d*W +: W]; m_hf[d] = 1; end
    end
  endtask

  task automatic compare();
    check(frame_valid == m_val, "R5/R6 strobe", 128'(frame_valid), 128'(m_val));
    check(frame_out == m_out, m_val ? "R2/R3 frame content" : "R9 frame hold",
          128'(frame_out), 128'(m_out));
    check(overrun == m_ovr, "R7 overrun", 128'(overrun), 128'(m_ovr));
  endtask

  task automatic tick(input logic [ND-1:0] fc, input logic [ND-1:0] vl);
    compare();
    dev_fclk = fc; dev_valid = vl;
    for (int d = 0; d < ND; d++) dev_data[d*W +: W] = dat(d, cyc);
    model_step();
    cyc++;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; dev_valid = '0; dev_fclk = '0;
    repeat (3) @(negedge clk);
    model_reset();
    rst = 1'b0;
    // R1: reset state visible at the ports
    check(frame_valid == 1'b0, "R1 valid after reset", 128'(frame_valid), 128'(0));
    check(frame_out == '0, "R1 frame after reset", 128'(frame_out), 128'(0));
    check(overrun == '0, "R1 overrun after reset", 128'(overrun), 128'(0));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int c0;
    @(negedge clk);
    do_reset();

    // table-driven walk (phases offset by one cycle, gaps, all-invalid rows)
    for (int i = 0; i < NROWS; i++) tick(TBL[i][3:0], TBL[i][7:4]);

    // random per-device phase offsets of zero or one cycle
    for (int s = 0; s < 6; s++) begin
      logic [ND-1:0] off;
      do_reset();
      off = ND'($urandom);
      for (int c = 0; c < 30; c++) tick(off ^ {ND{c[0]}}, '1);
    end

    // R4: stream starting with even halves must not pair them
    do_reset();
    c0 = cyc;
    tick('1, '1); tick('1, '1); tick('0, '1); tick('1, '1); tick('0, '1);
    check(frame_valid == 1'b1, "R4 first strobe", 128'(frame_valid), 128'(1));
    check(frame_out[0 +: W] == dat(0, c0 + 2), "R4 odd half", 128'(frame_out[0 +: W]), 128'(dat(0, c0 + 2)));
    check(frame_out[W +: W] == dat(0, c0 + 3), "R4 even half", 128'(frame_out[W +: W]), 128'(dat(0, c0 + 3)));

    // R8: invalid gap between odd and even halves
    do_reset();
    c0 = cyc;
    tick('1, '1); tick('0, '1); tick('1, '0); tick('1, '1); tick('0, '0);
    check(frame_valid == 1'b1, "R8 strobe after gap", 128'(frame_valid), 128'(1));
    check(frame_out[PW +: PW] == {dat(1, c0 + 3), dat(1, c0 + 1)}, "R8 pair across gap",
          128'(frame_out[PW +: PW]), 128'({dat(1, c0 + 3), dat(1, c0 + 1)}));

    // R7: device 3 silent, others complete twice
    do_reset();
    tick('1, 4'h7); tick('0, 4'h7); tick('1, 4'h7); tick('0, 4'h7); tick('1, 4'h7); tick('0, 4'h0);
    check(overrun == 4'h7, "R7 overrun set on double completion", 128'(overrun), 128'(4'h7));
    check(frame_valid == 1'b0, "R5 no strobe with silent device", 128'(frame_valid), 128'(0));
    tick('0, 4'h0);
    compare();

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule